// File: doc/BRIEF.md
# Host Data Bus Buffer for an 8-bit Slave Controller

This block is the host-facing register window of an 8-bit slave peripheral controller. A host processor sees two byte locations selected by an address bit: a data location it writes to pass a byte to the local processor, and a location it reads to collect either a byte left by the local processor or an 8-bit status word. Each direction has its own holding register, so a byte travelling one way never overwrites a byte travelling the other. Two full flags in the status word carry the handshake: the producer of a byte sets a flag, the consumer clears it.

On the internal side the local processor gets a read pulse for the inbound byte, a write port for the outbound byte, a copy of the status word and five firmware-owned status bits. It also drives an 8-bit general port latch and a small command input. One command reroutes two port bits so the host can see buffer-full conditions as pins; another turns the top port bit into an active-low DMA acknowledge input that selects the buffers the way chip select does. All host strobes are brought into the internal clock through two-flop synchronizers.

Top module: `hbuf_iface`

## Requirements
- R1: After reset both full flags and the command/data flag (status bits 0, 1, 3) are 0, the port latch and `p2_out` are 0xFF, and neither pin mode is enabled.
- R2: A selected host write (chip select low, write strobe low) stores `host_din` into the inbound register, sets status bit 1 (inbound full) and copies the address bit into status bit 3 (1 = command byte, 0 = data byte).
- R3: A one-cycle `loc_ibuf_rd` pulse clears status bit 1 in the following clock cycle, unless a host write completes in the same cycle.
- R4: A `loc_obuf_wr` pulse stores `loc_obuf_data` and sets status bit 0 (outbound full); a selected host read with address bit 0 returns that byte on `host_dout` and clears status bit 0.
- R5: A selected host read with address bit 1 returns the status word (bit 0 outbound full, bit 1 inbound full, bit 2 = `loc_user[0]`, bit 3 command/data, bits 7:4 = `loc_user[4:1]`) and changes neither full flag.
- R6: Strobes with chip select high and no active DMA acknowledge are ignored: no flag or register changes and `host_doe` stays 0.
- R7: Before the flag command (code 0xF5) `p2_out[5:4]` follow the port latch; afterwards `p2_out[4]` is latch bit 4 AND outbound full, and `p2_out[5]` is latch bit 5 AND NOT inbound full.
- R8: After the DMA command (code 0xE5) `p2_out[7]` is held 1 and a low `p2_in[7]` selects the buffers like chip select, with the address bit forced to 0: writes land as data bytes and reads return the outbound byte.
- R9: Before the DMA command a low `p2_in[7]` has no effect on the buffers.
- R10: A buffer operation updates state on the third rising clock edge after its strobe falls, and both pin modes stay enabled until reset.
- R11: `host_doe` is 1 exactly while the buffers are selected and the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_a0 | input | 1 | Host address bit: 1 status/command, 0 data |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data |
| host_doe | output | 1 | Host data bus drive enable |
| loc_ibuf_rd | input | 1 | Local read of inbound byte, one-cycle pulse |
| loc_ibuf_data | output | 8 | Inbound byte to the local processor |
| loc_obuf_wr | input | 1 | Local write of outbound byte, one-cycle pulse |
| loc_obuf_data | input | 8 | Outbound byte from the local processor |
| loc_user | input | 5 | Firmware-owned status bits |
| loc_status | output | 8 | Status word seen by the local processor |
| loc_cmd_valid | input | 1 | Command strobe |
| loc_cmd_code | input | 8 | Command code (0xF5 flags, 0xE5 DMA) |
| loc_p2_wr | input | 1 | Port latch write strobe |
| loc_p2_data | input | 8 | Port latch write value |
| p2_in | input | 8 | Port pin levels (bit 7 used as DMA acknowledge) |
| p2_out | output | 8 | Port pin drive values |

## Verification
The assertions assume the host holds the address bit and write data stable from the falling edge of a strobe until it rises, keeps each strobe low for at least three clock cycles, and never lowers both strobes together. They also assume a DMA acknowledge and a chip select are not asserted at once. The stimulus holds every strobe for four cycles with address, data and select set on the same falling clock edge, waits four cycles between operations, and keeps `p2_in[7]` high whenever chip select is used.

// File: rtl/hbuf_pkg.sv
// Shared constants for the host data bus buffer.
// Assumes an 8-bit status word and an 8-bit general port.
package hbuf_pkg;
    localparam int STW        = 8;   // status word width
    localparam int ST_OBF     = 0;   // outbound full
    localparam int ST_IBF     = 1;   // inbound full
    localparam int ST_F0      = 2;   // firmware flag
    localparam int ST_CD      = 3;   // command/data of last host write
    localparam int ST_USR_LO  = 4;   // first of four firmware bits
    localparam int USRW       = 5;   // firmware-owned bits in total
    localparam int PW         = 8;   // general port width
    localparam int PB_OBF     = 4;   // port bit showing outbound full
    localparam int PB_IBF     = 5;   // port bit showing not inbound full
    localparam int PB_DACK    = 7;   // port bit used as DMA acknowledge

    typedef struct packed {
        logic flags;
        logic dma;
    } pin_mode_t;
endpackage

// File: rtl/hbuf_sync.sv
// Two-flop synchronizer bank for asynchronous host inputs.
// Assumes each bit is independent; reset value is given per bit.
module hbuf_sync #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            // Two stages per bit to settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta[i] <= RST_VAL[i];
                    q[i]    <= RST_VAL[i];
                end else begin
                    meta[i] <= d[i];
                    q[i]    <= meta[i];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/hbuf_regs.sv
// Inbound/outbound byte registers and the handshake status word.
// Assumes synchronized active-low strobes and select, and that the
// address bit and write data are stable while a strobe is low.
module hbuf_regs
    import hbuf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_s,
    input  logic            rd_s_n,
    input  logic            wr_s_n,
    input  logic            a0_eff,
    input  logic [DW-1:0]   host_din,
    input  logic            loc_ibuf_rd,
    input  logic            loc_obuf_wr,
    input  logic [DW-1:0]   loc_obuf_data,
    input  logic [USRW-1:0] loc_user,
    output logic [DW-1:0]   ibuf_q,
    output logic [DW-1:0]   obuf_q,
    output logic [STW-1:0]  status
);
    logic rd_d, wr_d;
    logic wr_evt, rd_evt;
    logic ibf, obf, cd;

    // Remember previous strobe levels for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_d <= 1'b1;
            wr_d <= 1'b1;
        end else begin
            rd_d <= rd_s_n;
            wr_d <= wr_s_n;
        end
    end

    assign wr_evt = sel_s & ~wr_s_n & wr_d;
    assign rd_evt = sel_s & ~rd_s_n & rd_d;

    // Inbound register, inbound-full flag and command/data flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ibuf_q <= '0;
            ibf    <= 1'b0;
            cd     <= 1'b0;
        end else if (wr_evt) begin
            ibuf_q <= host_din;
            ibf    <= 1'b1;
            cd     <= a0_eff;
        end else if (loc_ibuf_rd) begin
            ibf    <= 1'b0;
        end
    end

    // Outbound register and outbound-full flag; a local write wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            obuf_q <= '0;
            obf    <= 1'b0;
        end else if (loc_obuf_wr) begin
            obuf_q <= loc_obuf_data;
            obf    <= 1'b1;
        end else if (rd_evt && !a0_eff) begin
            obf    <= 1'b0;
        end
    end

    // Assemble the status word.
    always_comb begin
        status                     = '0;
        status[ST_OBF]             = obf;
        status[ST_IBF]             = ibf;
        status[ST_F0]              = loc_user[0];
        status[ST_CD]              = cd;
        status[STW-1:ST_USR_LO]    = loc_user[USRW-1:1];
    end

    // R2: a completed host write leaves the inbound flag set.
    a_r2_ibf_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> status[ST_IBF]);
    // R2: the command/data flag follows the address bit of the write.
    a_r2_cd_capture: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> status[ST_CD] == $past(a0_eff));
    // R3: a local read with no competing write clears inbound full.
    a_r3_ibf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_ibuf_rd && !wr_evt) |=> !status[ST_IBF]);
    // R4: a local write leaves outbound full set.
    a_r4_obf_set: assert property (@(posedge clk) disable iff (!rst_n)
        loc_obuf_wr |=> status[ST_OBF]);
    // R4: a host data read with no competing write clears outbound full.
    a_r4_obf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && !a0_eff && !loc_obuf_wr) |=> !status[ST_OBF]);
    // R5: a status read leaves outbound full unchanged.
    a_r5_status_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && a0_eff && !loc_obuf_wr) |=> $stable(status[ST_OBF]));
    // R6: inbound full only rises on a selected host write.
    a_r6_ibf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_IBF]) |-> $past(wr_evt));
    // R11: read and write edges are never seen together.
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_evt && wr_evt));
endmodule

// File: rtl/hbuf_portmux.sv
// General port latch with command-controlled pin modes: buffer-full
// flags on two bits and a DMA acknowledge input on the top bit.
// Assumes commands arrive as one-cycle strobes; modes stick until reset.
module hbuf_portmux
    import hbuf_pkg::*;
#(
    parameter logic [7:0] FLAG_CODE = 8'hF5,
    parameter logic [7:0] DMA_CODE  = 8'hE5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [7:0]    cmd_code,
    input  logic          p2_wr,
    input  logic [PW-1:0] p2_wdata,
    input  logic          obf,
    input  logic          ibf,
    output pin_mode_t     mode,
    output logic [PW-1:0] p2_out
);
    logic [PW-1:0] latch;

    // Decode mode commands; each mode stays on once set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '0;
        end else if (cmd_valid) begin
            if (cmd_code == FLAG_CODE) mode.flags <= 1'b1;
            if (cmd_code == DMA_CODE)  mode.dma   <= 1'b1;
        end
    end

    // Port output latch written by the local processor.
    always_ff @(posedge clk) begin
        if (!rst_n) latch <= '1;
        else if (p2_wr) latch <= p2_wdata;
    end

    // Pin drive values, with mode overrides per bit.
    always_comb begin
        p2_out = latch;
        if (mode.flags) begin
            p2_out[PB_OBF] = latch[PB_OBF] & obf;
            p2_out[PB_IBF] = latch[PB_IBF] & ~ibf;
        end
        if (mode.dma) p2_out[PB_DACK] = 1'b1;
    end

    // R10: the flag mode is never withdrawn before reset.
    a_r10_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        mode.flags |=> mode.flags);
    // R10: the DMA mode is never withdrawn before reset.
    a_r10_dma_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        mode.dma |=> mode.dma);
    // R8: the acknowledge pin is released high in DMA mode.
    a_r8_dack_pin_high: assert property (@(posedge clk) disable iff (!rst_n)
        mode.dma |-> p2_out[PB_DACK]);
    // R7: the outbound flag pin is low while the buffer is empty.
    a_r7_obf_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (mode.flags && !obf) |-> !p2_out[PB_OBF]);
endmodule

// File: rtl/hbuf_iface.sv
// Top of the host data bus buffer: synchronizes host strobes, forms the
// buffer select from chip select or DMA acknowledge, drives the host
// read bus and ties the register and port blocks together.
// Assumes address bit and data are stable while a strobe is low.
module hbuf_iface
    import hbuf_pkg::*;
#(
    parameter int         DW        = 8,
    parameter logic [7:0] FLAG_CODE = 8'hF5,
    parameter logic [7:0] DMA_CODE  = 8'hE5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_cs_n,
    input  logic            host_a0,
    input  logic            host_rd_n,
    input  logic            host_wr_n,
    input  logic [DW-1:0]   host_din,
    output logic [DW-1:0]   host_dout,
    output logic            host_doe,
    input  logic            loc_ibuf_rd,
    output logic [DW-1:0]   loc_ibuf_data,
    input  logic            loc_obuf_wr,
    input  logic [DW-1:0]   loc_obuf_data,
    input  logic [USRW-1:0] loc_user,
    output logic [STW-1:0]  loc_status,
    input  logic            loc_cmd_valid,
    input  logic [7:0]      loc_cmd_code,
    input  logic            loc_p2_wr,
    input  logic [PW-1:0]   loc_p2_data,
    input  logic [PW-1:0]   p2_in,
    output logic [PW-1:0]   p2_out
);
    localparam int NSYNC = 4;

    logic [NSYNC-1:0] raw_v, syn_v;
    pin_mode_t        mode;
    logic             dack_raw, dack_s, sel_raw, sel_s, a0_eff;
    logic [DW-1:0]    obuf_q;
    logic [STW-1:0]   status;

    assign raw_v = {p2_in[PB_DACK], host_cs_n, host_rd_n, host_wr_n};

    hbuf_sync #(.W(NSYNC), .RST_VAL('1)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d   (raw_v),
        .q   (syn_v)
    );

    // Select: chip select, or an enabled and asserted DMA acknowledge.
    assign dack_raw = mode.dma & ~p2_in[PB_DACK];
    assign dack_s   = mode.dma & ~syn_v[3];
    assign sel_raw  = ~host_cs_n | dack_raw;
    assign sel_s    = ~syn_v[2] | dack_s;
    assign a0_eff   = host_a0 & ~dack_raw;

    hbuf_regs #(.DW(DW)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .sel_s         (sel_s),
        .rd_s_n        (syn_v[1]),
        .wr_s_n        (syn_v[0]),
        .a0_eff        (a0_eff),
        .host_din      (host_din),
        .loc_ibuf_rd   (loc_ibuf_rd),
        .loc_obuf_wr   (loc_obuf_wr),
        .loc_obuf_data (loc_obuf_data),
        .loc_user      (loc_user),
        .ibuf_q        (loc_ibuf_data),
        .obuf_q        (obuf_q),
        .status        (status)
    );

    hbuf_portmux #(.FLAG_CODE(FLAG_CODE), .DMA_CODE(DMA_CODE)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (loc_cmd_valid),
        .cmd_code  (loc_cmd_code),
        .p2_wr     (loc_p2_wr),
        .p2_wdata  (loc_p2_data),
        .obf       (status[ST_OBF]),
        .ibf       (status[ST_IBF]),
        .mode      (mode),
        .p2_out    (p2_out)
    );

    // Host read bus: status or outbound byte, driven only when selected.
    always_comb begin
        host_doe  = sel_raw & ~host_rd_n;
        host_dout = a0_eff ? status : obuf_q;
    end

    assign loc_status = status;

    // R11: the bus is never driven while unselected.
    a_r11_doe_sel: assert property (@(posedge clk) disable iff (!rst_n)
        host_doe |-> (!host_cs_n || (mode.dma && !p2_in[PB_DACK])));
    // R8: under DMA acknowledge a read always returns the outbound byte.
    a_r8_dack_data: assert property (@(posedge clk) disable iff (!rst_n)
        (dack_raw && host_doe) |-> host_dout == obuf_q);
endmodule

// File: tb/hbuf_iface_bench.sv
// Self-checking bench: a vector table of host-write / local-write pairs
// walked by one loop, then directed tests for reset, status reads,
// ignored strobes, pin flag mode and DMA acknowledge.
module hbuf_iface_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cs_n = 1'b1, host_a0 = 1'b0, host_rd_n = 1'b1, host_wr_n = 1'b1;
    logic [7:0] host_din = '0, host_dout;
    logic       host_doe;
    logic       loc_ibuf_rd = 1'b0, loc_obuf_wr = 1'b0;
    logic [7:0] loc_ibuf_data, loc_obuf_data = '0, loc_status;
    logic [4:0] loc_user = '0;
    logic       loc_cmd_valid = 1'b0, loc_p2_wr = 1'b0;
    logic [7:0] loc_cmd_code = '0, loc_p2_data = '0, p2_in = 8'hFF, p2_out;

    int total = 0, bad = 0;
    logic [7:0] rd_val;
    logic       rd_oe;

    always #2.5 clk = ~clk;

    hbuf_iface u_hbuf_iface (.*);

    // Each entry: {host a0, host write byte, local outbound byte}.
    localparam int NV = 6;
    localparam logic [16:0] VEC [NV] = '{
        {1'b0, 8'h3C, 8'hA5},
        {1'b1, 8'hD4, 8'h00},
        {1'b0, 8'hFF, 8'h7E},
        {1'b1, 8'h00, 8'hFF},
        {1'b0, 8'h81, 8'h18},
        {1'b1, 8'h5A, 8'hC3}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(input logic sel_cs, input logic a0, input logic [7:0] d);
        @(negedge clk);
        host_cs_n = ~sel_cs; host_a0 = a0; host_din = d; host_wr_n = 1'b0;
        idle(4);
        host_wr_n = 1'b1; host_cs_n = 1'b1;
        idle(4);
    endtask

    task automatic host_read(input logic sel_cs, input logic a0);
        @(negedge clk);
        host_cs_n = ~sel_cs; host_a0 = a0; host_rd_n = 1'b0;
        #1;
        rd_val = host_dout; rd_oe = host_doe;
        idle(4);
        host_rd_n = 1'b1; host_cs_n = 1'b1;
        idle(4);
    endtask

    task automatic loc_read();
        @(negedge clk); loc_ibuf_rd = 1'b1;
        @(negedge clk); loc_ibuf_rd = 1'b0;
        idle(1);
    endtask

    task automatic loc_write(input logic [7:0] d);
        @(negedge clk); loc_obuf_wr = 1'b1; loc_obuf_data = d;
        @(negedge clk); loc_obuf_wr = 1'b0;
        idle(1);
    endtask

    task automatic loc_cmd(input logic [7:0] c);
        @(negedge clk); loc_cmd_valid = 1'b1; loc_cmd_code = c;
        @(negedge clk); loc_cmd_valid = 1'b0;
        idle(1);
    endtask

    task automatic port_write(input logic [7:0] d);
        @(negedge clk); loc_p2_wr = 1'b1; loc_p2_data = d;
        @(negedge clk); loc_p2_wr = 1'b0;
        idle(1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1: reset state.
        chk("R1 status", loc_status & 8'h0B, 8'h00);
        chk("R1 port", p2_out, 8'hFF);

        // Vector walk: R2, R3, R4.
        for (int i = 0; i < NV; i++) begin
            host_write(1'b1, VEC[i][16], VEC[i][15:8]);
            chk("R2 ibuf", loc_ibuf_data, VEC[i][15:8]);
            chk("R2 ibf/cd", loc_status & 8'h0A, {4'h0, VEC[i][16], 3'b010});
            loc_read();
            chk("R3 ibf clear", {7'h0, loc_status[1]}, 8'h00);
            loc_write(VEC[i][7:0]);
            chk("R4 obf set", {7'h0, loc_status[0]}, 8'h01);
            host_read(1'b1, 1'b0);
            chk("R4 read data", rd_val, VEC[i][7:0]);
            chk("R11 doe", {7'h0, rd_oe}, 8'h01);
            chk("R4 obf clear", {7'h0, loc_status[0]}, 8'h00);
        end

        // R5: status read returns the word and keeps the flags.
        loc_user = 5'b10110;
        loc_write(8'h44);
        host_write(1'b1, 1'b1, 8'h99);
        host_read(1'b1, 1'b1);
        chk("R5 status word", rd_val, 8'b1011_1011);
        chk("R5 flags kept", loc_status & 8'h03, 8'h03);
        loc_read();
        host_read(1'b1, 1'b0);
        loc_user = '0;

        // R6: unselected strobes are ignored.
        host_write(1'b0, 1'b0, 8'h12);
        chk("R6 no write", {7'h0, loc_status[1]}, 8'h00);
        chk("R6 ibuf kept", loc_ibuf_data, 8'h99);
        loc_write(8'h21);
        host_read(1'b0, 1'b0);
        chk("R6 doe off", {7'h0, rd_oe}, 8'h00);
        chk("R6 obf kept", {7'h0, loc_status[0]}, 8'h01);

        // R10: update lands on the third rising edge after the strobe.
        @(negedge clk);
        host_cs_n = 1'b0; host_a0 = 1'b0; host_din = 8'h66; host_wr_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R10 not yet", {7'h0, loc_status[1]}, 8'h00);
        @(negedge clk);
        chk("R10 landed", {7'h0, loc_status[1]}, 8'h01);
        host_wr_n = 1'b1; host_cs_n = 1'b1;
        idle(4);

        // R7: flag pins. State now: OBF=1, IBF=1.
        chk("R7 before cmd", p2_out, 8'hFF);
        loc_read();
        host_read(1'b1, 1'b0);
        loc_cmd(8'hF5);
        chk("R7 obf pin low", {7'h0, p2_out[4]}, 8'h00);
        chk("R7 ibf pin high", {7'h0, p2_out[5]}, 8'h01);
        loc_write(8'h0F);
        chk("R7 obf pin high", {7'h0, p2_out[4]}, 8'h01);
        port_write(8'hEF);
        chk("R7 latch forces low", {7'h0, p2_out[4]}, 8'h00);
        port_write(8'hFF);
        host_write(1'b1, 1'b0, 8'h31);
        chk("R7 ibf pin low", {7'h0, p2_out[5]}, 8'h00);
        loc_read();
        loc_cmd(8'h00);
        chk("R10 flags stay", {6'h0, p2_out[5:4]}, 8'h03);

        // R9: acknowledge ignored before the DMA command.
        p2_in[7] = 1'b0;
        host_write(1'b0, 1'b0, 8'h77);
        chk("R9 no dack write", {7'h0, loc_status[1]}, 8'h00);
        p2_in[7] = 1'b1;
        idle(4);

        // R8: DMA acknowledge selects buffers with address bit forced 0.
        port_write(8'h7F);
        loc_cmd(8'hE5);
        chk("R8 pin high", {7'h0, p2_out[7]}, 8'h01);
        p2_in[7] = 1'b0;
        host_write(1'b0, 1'b1, 8'hB2);
        chk("R8 dack write", loc_ibuf_data, 8'hB2);
        chk("R8 as data", loc_status & 8'h0A, 8'h02);
        host_read(1'b0, 1'b1);
        chk("R8 dack read", rd_val, 8'h0F);
        chk("R8 obf clear", {7'h0, loc_status[0]}, 8'h00);
        p2_in[7] = 1'b1;
        idle(4);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule